// File: doc/BRIEF.md
# Deferred Frame CRC-16 Checker

This block runs a CRC-16 over a serial multiplex stream one bit at a time. The generator is x^16 + x^12 + x^5 + 1. The register restarts at each frame boundary, so every frame of 2,560 line bits has its own remainder. The remainder covers the whole frame, padding included. It is not appended at the end of its frame. It travels one frame late, as four 4-bit nibbles, with one nibble in each of the four subframes of the next frame.

The same block serves both directions. On the transmit side, the latched remainder of the previous frame is offered on `fcc_tx_rem`. The bit due in the current check slot is offered on `fcc_tx_check_bit`, so the frame builder can drop it into the stream. On the receive side, the 16 check bits of a frame are collected and compared with the remainder the block computed over the frame before. The result is one error flag per frame, with a valid strobe.

Comparison only takes place while the receiver holds frame alignment. Any loss of alignment blanks the current frame. After a loss of alignment, the first complete frame is also not checked, because its reference remainder was built from misaligned data. Frame alignment itself is done elsewhere; this block only consumes the strobes and the in-frame flag.

Top module: `frame_crc_checker`

## Requirements
- R1: The CRC register starts from zero on the bit marked by `fcc_frame_start` and shifts in every accepted bit most significant first with generator 0x1021. On that same bit, the remainder of the frame just ended is latched. `fcc_tx_rem` shows the latched remainder from the cycle after that bit, and it holds it until the next frame start.
- R2: A cycle with `fcc_bit_en` low changes no state: the strobes and the data bit are ignored, and idle cycles inside a frame leave all results unchanged.
- R3: Check slots are numbered by arrival within the frame. The n-th check bit (n = 0..15) maps to word bit 15-n. The first subframe therefore carries bits 15..12 and the fourth subframe carries bits 3..0, each nibble most significant bit first. During a check slot, `fcc_tx_check_bit` equals the latched remainder bit for that slot.
- R4: When checking is enabled, `fcc_chk_valid` pulses high for exactly one cycle. The pulse comes in the cycle after the fourth check bit of the fourth subframe is accepted. In that cycle, `fcc_chk_err` is high when the collected word differs from the latched remainder.
- R5: When the collected word equals the latched remainder, `fcc_chk_err` stays low while `fcc_chk_valid` pulses.
- R6: A frame in which `fcc_in_frame` goes low at any time, including a frame that starts while it is low, produces no valid pulse and no error pulse.
- R7: The first complete frame after an out-of-frame frame or after reset is not checked. The frame after that is checked again.
- R8: Synchronous reset clears `fcc_tx_rem`, `fcc_tx_check_bit`, `fcc_chk_valid` and `fcc_chk_err` to zero.
- R9: `fcc_chk_err` is never high unless `fcc_chk_valid` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fcc_bit_en | input | 1 | Qualifies all other stream inputs in this cycle |
| fcc_bit_in | input | 1 | Serial line bit |
| fcc_frame_start | input | 1 | Marks the first bit of a frame |
| fcc_subframe_start | input | 1 | Marks the first bit of subframes two to four |
| fcc_check_slot | input | 1 | Marks a bit that carries a check nibble bit |
| fcc_in_frame | input | 1 | High while frame alignment is held |
| fcc_tx_rem | output | 16 | Latched remainder of the previous frame |
| fcc_tx_check_bit | output | 1 | Remainder bit due in the current check slot |
| fcc_chk_valid | output | 1 | One-cycle strobe: a frame comparison was made |
| fcc_chk_err | output | 1 | Comparison mismatch, qualified by the strobe |

## Verification
A corrupted CRC register or a wrong latch shows up one cycle after the next frame start, as a wrong `fcc_tx_rem`. It also shows up through the check-slot bits offered during that frame. A wrong slot pointer puts check bits into the wrong word positions. That is visible within the same frame on `fcc_tx_check_bit`, and as a spurious error one cycle after the last check bit. A wrong alignment state only shows at the end of the frame's fourth check nibble, as a missing or an extra strobe. For that reason the stimulus walks loss of alignment both in the middle of a frame and across a whole frame, and then the recovery frames after it.

// File: rtl/fcrc_pkg.sv
package fcrc_pkg;

    localparam int              CRC_W     = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
    localparam int              SUBFRAMES = 4;
    localparam int              NIB_BITS  = CRC_W / SUBFRAMES;
    localparam int              SF_W      = $clog2(SUBFRAMES);
    localparam int              NB_W      = $clog2(NIB_BITS);
    localparam int              POS_W     = SF_W + NB_W;

    typedef logic [CRC_W-1:0] crc_t;

    typedef struct packed {
        logic en;
        logic data;
        logic fsof;
        logic ssof;
        logic slot;
    } bit_ev_t;

    typedef enum logic [1:0] {
        CK_BLIND = 2'd0,
        CK_WARM  = 2'd1,
        CK_LIVE  = 2'd2
    } ck_state_e;

    function automatic crc_t crc_step(crc_t r, logic b);
        logic fb;
        fb = r[CRC_W-1] ^ b;
        return {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/fcrc_accum.sv
module fcrc_accum
    import fcrc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bit_ev_t ev,
    output crc_t    rem_q
);

    crc_t crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= '0;
            rem_q <= '0;
        end else if (ev.en) begin
            if (ev.fsof) begin
                rem_q <= crc_q;
                crc_q <= crc_step('0, ev.data);
            end else begin
                crc_q <= crc_step(crc_q, ev.data);
            end
        end
    end

    // R1: latched remainder only moves on an accepted frame start
    p_rem_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !(ev.en && ev.fsof) |=> $stable(rem_q));

endmodule

// File: rtl/fcrc_slot_track.sv
module fcrc_slot_track
    import fcrc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bit_ev_t ev,
    input  crc_t    rem_q,
    output logic    tx_bit,
    output crc_t    rx_next,
    output logic    last_slot
);

    logic [SF_W-1:0]  sf_q;
    logic [NB_W-1:0]  nib_q;
    logic [POS_W-1:0] pos_idx;
    crc_t             rx_q;

    // slot n of the frame lands in word bit CRC_W-1-n
    assign pos_idx   = ~{sf_q, nib_q};
    assign tx_bit    = rem_q[pos_idx];
    assign last_slot = ev.en && ev.slot && (&sf_q) && (&nib_q);

    always_comb begin
        rx_next = rx_q;
        if (ev.en && ev.slot) begin
            rx_next[pos_idx] = ev.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sf_q  <= '0;
            nib_q <= '0;
            rx_q  <= '0;
        end else if (ev.en) begin
            rx_q <= rx_next;
            if (ev.fsof) begin
                sf_q  <= '0;
                nib_q <= '0;
            end else if (ev.ssof) begin
                sf_q  <= sf_q + SF_W'(1);
                nib_q <= '0;
            end else if (ev.slot) begin
                nib_q <= nib_q + NB_W'(1);
            end
        end
    end

    // R3: the final slot of a frame cannot repeat on the next bit
    p_last_once_r3: assert property (@(posedge clk) disable iff (rst)
        last_slot |=> !last_slot);

endmodule

// File: rtl/fcrc_gate.sv
module fcrc_gate
    import fcrc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bit_ev_t ev,
    input  logic    in_frame,
    input  logic    last_slot,
    input  crc_t    rx_next,
    input  crc_t    rem_q,
    output logic    chk_valid,
    output logic    chk_err
);

    ck_state_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= CK_BLIND;
            chk_valid <= 1'b0;
            chk_err   <= 1'b0;
        end else begin
            chk_valid <= 1'b0;
            chk_err   <= 1'b0;
            if (!in_frame) begin
                st_q <= CK_BLIND;
            end else if (ev.en && ev.fsof) begin
                st_q <= (st_q == CK_BLIND) ? CK_WARM : CK_LIVE;
            end
            if (last_slot && in_frame && st_q == CK_LIVE) begin
                chk_valid <= 1'b1;
                chk_err   <= (rx_next != rem_q);
            end
        end
    end

    // R9: error is always qualified by the strobe
    p_err_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
        chk_err |-> chk_valid);

    // R4: strobe is a single-cycle pulse
    p_valid_single_r4: assert property (@(posedge clk) disable iff (rst)
        chk_valid |=> !chk_valid);

    // R4: strobe only follows the final check bit of a frame
    p_valid_after_slot_r4: assert property (@(posedge clk) disable iff (rst)
        chk_valid |-> $past(last_slot));

    // R6: no comparison comes out of an out-of-frame cycle
    p_oof_silent_r6: assert property (@(posedge clk) disable iff (rst)
        !in_frame |=> !chk_valid);

endmodule

// File: rtl/frame_crc_checker.sv
module frame_crc_checker
    import fcrc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fcc_bit_en,
    input  logic             fcc_bit_in,
    input  logic             fcc_frame_start,
    input  logic             fcc_subframe_start,
    input  logic             fcc_check_slot,
    input  logic             fcc_in_frame,
    output logic [CRC_W-1:0] fcc_tx_rem,
    output logic             fcc_tx_check_bit,
    output logic             fcc_chk_valid,
    output logic             fcc_chk_err
);

    bit_ev_t ev;
    crc_t    rem_q;
    crc_t    rx_next;
    logic    last_slot;

    assign ev.en   = fcc_bit_en;
    assign ev.data = fcc_bit_in;
    assign ev.fsof = fcc_frame_start;
    assign ev.ssof = fcc_subframe_start;
    assign ev.slot = fcc_check_slot;

    fcrc_accum u_accum (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .rem_q (rem_q)
    );

    fcrc_slot_track u_slots (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .rem_q     (rem_q),
        .tx_bit    (fcc_tx_check_bit),
        .rx_next   (rx_next),
        .last_slot (last_slot)
    );

    fcrc_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .in_frame  (fcc_in_frame),
        .last_slot (last_slot),
        .rx_next   (rx_next),
        .rem_q     (rem_q),
        .chk_valid (fcc_chk_valid),
        .chk_err   (fcc_chk_err)
    );

    assign fcc_tx_rem = rem_q;

endmodule

// File: tb/test_frame_crc_checker.sv
module test_frame_crc_checker;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME_BITS = 2560;
    localparam int SUB_BITS   = 640;
    localparam int N_VEC      = 13;
    localparam int WD_CYCLES  = 190000;

    // vector bits: [5] data flip, [4] check flip, [3:2] align loss
    // (0 none, 1 mid-frame gap, 2 whole frame), [1] idle gaps, [0] expect strobe
    localparam logic [5:0] VECS [0:N_VEC-1] = '{
        6'b000000, 6'b000001, 6'b100001, 6'b000011, 6'b010001,
        6'b000001, 6'b000100, 6'b000000, 6'b000011, 6'b001000,
        6'b000000, 6'b100001, 6'b000001
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        fcc_bit_en, fcc_bit_in, fcc_frame_start, fcc_subframe_start;
    logic        fcc_check_slot, fcc_in_frame;
    logic [15:0] fcc_tx_rem;
    logic        fcc_tx_check_bit, fcc_chk_valid, fcc_chk_err;

    frame_crc_checker i_frame_crc_checker (
        .clk                (clk),
        .rst                (rst),
        .fcc_bit_en         (fcc_bit_en),
        .fcc_bit_in         (fcc_bit_in),
        .fcc_frame_start    (fcc_frame_start),
        .fcc_subframe_start (fcc_subframe_start),
        .fcc_check_slot     (fcc_check_slot),
        .fcc_in_frame       (fcc_in_frame),
        .fcc_tx_rem         (fcc_tx_rem),
        .fcc_tx_check_bit   (fcc_tx_check_bit),
        .fcc_chk_valid      (fcc_chk_valid),
        .fcc_chk_err        (fcc_chk_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          n_cmp = 0;
    int          n_bad = 0;
    int          vcnt, ecnt;
    logic [15:0] rx_prev, tx_prev;
    logic        rem_pending;
    logic [15:0] exp_rem;
    logic        tx_sample;
    bit          done = 0;

    function automatic logic [15:0] ref_step(logic [15:0] r, logic b);
        logic [15:0] nx;
        nx = r << 1;
        if (r[15] ^ b) nx = nx ^ 16'h1021;
        return nx;
    endfunction

    function automatic int slot_index(int b);
        int o;
        o = b % SUB_BITS;
        if ((o % 16) == 15 && (o / 16) < 4) return (b / SUB_BITS) * 4 + o / 16;
        return -1;
    endfunction

    function automatic logic data_bit(int f, int b);
        int v;
        v = (b * b + f * 13 + b / 3) ^ (b >> 4);
        return v[0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input logic en, input logic d, input logic fs,
                        input logic ss, input logic cs, input logic inf);
        @(negedge clk);
        if (fcc_chk_valid) vcnt++;
        if (fcc_chk_err) ecnt++;
        if (rem_pending) begin
            check(fcc_tx_rem == exp_rem, "R1", "remainder after frame start",
                  32'(fcc_tx_rem), 32'(exp_rem));
            rem_pending = 1'b0;
        end
        if (cs) tx_sample = fcc_tx_check_bit;
        fcc_bit_en         = en;
        fcc_bit_in         = d;
        fcc_frame_start    = fs;
        fcc_subframe_start = ss;
        fcc_check_slot     = cs;
        fcc_in_frame       = inf;
    endtask

    task automatic run_frame(input int f, input logic [5:0] v);
        logic [15:0] rx_acc, tx_acc, rx_word, txw;
        logic        inf, sbit, rbit, exp_err;
        int          si;
        string       rq;
        rx_acc = '0; tx_acc = '0; rx_word = '0; txw = '0;
        vcnt = 0; ecnt = 0;
        for (int b = 0; b < FRAME_BITS; b++) begin
            inf = !(v[3:2] == 2'd2) && !(v[3:2] == 2'd1 && b >= 700 && b < 800);
            si  = slot_index(b);
            if (v[1] && (b % 3) == 1) tick(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, inf);
            sbit = (si >= 0) ? tx_prev[15 - si] : data_bit(f, b);
            rbit = sbit ^ ((v[5] && b == 1000) || (v[4] && b == SUB_BITS + 15));
            tx_acc = ref_step(tx_acc, sbit);
            rx_acc = ref_step(rx_acc, rbit);
            tick(1'b1, rbit, b == 0, (b % SUB_BITS) == 0 && b != 0, si >= 0, inf);
            if (si >= 0) begin
                rx_word[15 - si] = rbit;
                txw[15 - si]     = tx_sample;
            end
            if (b == 0) begin
                rem_pending = 1'b1;
                exp_rem     = rx_prev;
            end
        end
        rq = v[1] ? "R2/R4" : (v[3:2] != 0 ? "R6" : "R4");
        if (!v[0]) rq = (v[3:2] != 0) ? "R6" : "R7";
        check(vcnt == int'(v[0]), rq, $sformatf("strobe count frame %0d", f),
              32'(vcnt), 32'(v[0]));
        exp_err = v[0] && (rx_word != rx_prev);
        check(ecnt == int'(exp_err), exp_err ? "R4" : "R5",
              $sformatf("error count frame %0d", f), 32'(ecnt), 32'(exp_err));
        check(txw == rx_prev, "R3", $sformatf("offered check word frame %0d", f),
              32'(txw), 32'(rx_prev));
        rx_prev = rx_acc;
        tx_prev = tx_acc;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        fcc_bit_en = 0; fcc_bit_in = 0; fcc_frame_start = 0;
        fcc_subframe_start = 0; fcc_check_slot = 0; fcc_in_frame = 1;
        rx_prev = '0; tx_prev = '0; rem_pending = 1'b0; exp_rem = '0; tx_sample = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        check(fcc_tx_rem == 16'h0, "R8", "tx remainder", 32'(fcc_tx_rem), 32'h0);
        check(fcc_tx_check_bit == 1'b0, "R8", "tx check bit", 32'(fcc_tx_check_bit), 32'h0);
        check(fcc_chk_valid == 1'b0, "R8", "strobe", 32'(fcc_chk_valid), 32'h0);
        check(fcc_chk_err == 1'b0, "R8", "error", 32'(fcc_chk_err), 32'h0);

        for (int i = 0; i < N_VEC; i++) run_frame(i, VECS[i]);

        // R8: reset in the middle of a running stream
        tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        rst = 1'b1;
        repeat (2) tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check(fcc_tx_rem == 16'h0, "R8", "tx remainder after late reset",
              32'(fcc_tx_rem), 32'h0);
        rx_prev = '0; tx_prev = '0;
        // R7: first frame after reset is not checked, the next one is
        run_frame(20, 6'b000000);
        run_frame(21, 6'b100001);
        run_frame(22, 6'b000001);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule